// File: doc/BRIEF.md
# DQS Read/Write Phase Adjust Controller

This block produces the delay codes for the read-strobe and write-strobe phase shifters of a DDR memory controller. Its base is the control code of a locked delay-locked loop, which on its own gives a strobe delayed by a quarter clock period. Once the DLL is locked, the controller adds a separate signed trim to that base for each direction. The core system uses these trims to offset interconnect skew between the controller and the memory devices. The shifter delay lines use the same code format as the DLL's own line, so the codes leave this block without any re-encoding.

A trim is captured only when the adjustment strobe is high. Each output code then walks toward its new target one LSB per clock. This keeps a large correction from becoming a sudden phase jump on a live strobe. While the DLL is out of lock, both codes follow the base code and any trim held so far is dropped. A settled flag tells the core that both codes have reached their targets.

Top module: `dqs_phase_ctrl`

## Requirements
- R1: With both stored trims at zero and the DLL locked, the read and write codes settle to the DLL code.
- R2: The read code and the write code each follow only their own trim input. A trim on one side never moves the other code.
- R3: A trim is a two's-complement value ADJ_W bits wide. Each target equals the DLL code plus the stored trim, clamped to the range 0 to 2^CODE_W-1.
- R4: While the lock input is low, each code is loaded with the DLL code on every clock and the stored trims are cleared to zero. A trim captured before the loss of lock has no effect after re-lock.
- R5: While locked, a code that differs from its target moves by exactly one LSB per clock in the direction of the target. A trim strobed at clock edge k gives the first step at edge k+1.
- R6: The settled output is high exactly when both codes equal their current targets. While the block is locked and settled, the codes hold.
- R7: A strobe that arrives while a code is still stepping replaces the target. Stepping continues from the current code toward the new target.
- R8: A change of the DLL code while locked recomputes both targets, and the codes step to the new targets.
- R9: While reset is asserted, and for two clocks after it is released, both codes read zero.
- R10: Trim inputs that change without the strobe have no effect on either code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dll_locked | input | 1 | DLL lock indication |
| dll_code | input | CODE_W | DLL control code for a quarter-period delay |
| rd_adj | input | ADJ_W | Signed trim for the read strobe |
| wr_adj | input | ADJ_W | Signed trim for the write strobe |
| adj_stb | input | 1 | Captures both trim inputs |
| rd_code | output | CODE_W | Delay code for the read strobe shifter |
| wr_code | output | CODE_W | Delay code for the write strobe shifter |
| settled | output | 1 | Both codes equal their targets |

## Verification
The hardest behaviour to reach is clamping at both ends of the code range, because clamping only occurs when a large base and a large trim combine. The stimulus first stores extreme trims and then moves the DLL code high and then low while the block stays locked. The high base sends the read target past the top of the range, and the low base sends the write target below zero. The stimulus also fires a second strobe while a code is still walking, to show that the target is replaced. It drops lock with a trim still stored, to show that the trim is lost. A behavioural model advances with the clock and is compared with the outputs on every cycle.

// File: rtl/dqs_phase_pkg.sv
package dqs_phase_pkg;
  typedef enum logic [0:0] {
    CH_READ  = 1'b0,
    CH_WRITE = 1'b1
  } dqs_ch_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/dqs_target_calc.sv
module dqs_target_calc #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADJ_W  = 6
) (
  input  logic [CODE_W-1:0]       base_i,
  input  logic signed [ADJ_W-1:0] adj_i,
  output logic [CODE_W-1:0]       tgt_o
);
  localparam int unsigned SUM_W = ((CODE_W > ADJ_W) ? CODE_W : ADJ_W) + 2;
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'({CODE_W{1'b1}});

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = $signed({{(SUM_W-CODE_W){1'b0}}, base_i}) + SUM_W'(adj_i);
    if (sum < 0) begin
      tgt_o = '0;
    end else if (sum > MAX_S) begin
      tgt_o = '1;
    end else begin
      tgt_o = sum[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/dqs_code_stepper.sv
module dqs_code_stepper #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADJ_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lock_i,
  input  logic [CODE_W-1:0]       base_i,
  input  logic signed [ADJ_W-1:0] adj_i,
  input  logic                    stb_i,
  output logic [CODE_W-1:0]       code_o,
  output logic                    at_tgt_o
);
  logic signed [ADJ_W-1:0] adj_q, adj_d;
  logic [CODE_W-1:0]       code_q, code_d;
  logic [CODE_W-1:0]       tgt;
  logic                    upd_en;

  dqs_target_calc #(.CODE_W(CODE_W), .ADJ_W(ADJ_W)) u_calc (
    .base_i (base_i),
    .adj_i  (adj_q),
    .tgt_o  (tgt)
  );

  assign upd_en = !lock_i || stb_i || (code_q != tgt);

  always_comb begin
    adj_d  = adj_q;
    code_d = code_q;
    if (!lock_i) begin
      adj_d  = '0;
      code_d = base_i;
    end else begin
      if (stb_i) adj_d = adj_i;
      if (code_q < tgt) begin
        code_d = code_q + 1'b1;
      end else if (code_q > tgt) begin
        code_d = code_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_q  <= '0;
      code_q <= '0;
    end else if (upd_en) begin
      adj_q  <= adj_d;
      code_q <= code_d;
    end
  end

  assign code_o   = code_q;
  assign at_tgt_o = (code_q == tgt);

  // R5: locked codes move by at most one LSB per clock
  p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1 ||
                code_q == $past(code_q) - 1'b1));

  // R5: a code below its target rises next clock
  p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && code_q < tgt) |=> code_q == $past(code_q) + 1'b1);

  // R4: unlocked loads the base and clears the stored trim
  p_unlock_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> (code_q == $past(base_i) && adj_q == '0));
endmodule

// File: rtl/dqs_phase_ctrl.sv
module dqs_phase_ctrl #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADJ_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dll_locked,
  input  logic [CODE_W-1:0] dll_code,
  input  logic [ADJ_W-1:0]  rd_adj,
  input  logic [ADJ_W-1:0]  wr_adj,
  input  logic              adj_stb,
  output logic [CODE_W-1:0] rd_code,
  output logic [CODE_W-1:0] wr_code,
  output logic              settled
);
  import dqs_phase_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic signed [ADJ_W-1:0] adj_arr  [NUM_CH];
  logic [CODE_W-1:0]       code_arr [NUM_CH];
  logic [NUM_CH-1:0]       at_tgt;

  assign adj_arr[CH_READ]  = $signed(rd_adj);
  assign adj_arr[CH_WRITE] = $signed(wr_adj);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dqs_code_stepper #(.CODE_W(CODE_W), .ADJ_W(ADJ_W)) u_step (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .lock_i   (dll_locked),
      .base_i   (dll_code),
      .adj_i    (adj_arr[ch]),
      .stb_i    (adj_stb),
      .code_o   (code_arr[ch]),
      .at_tgt_o (at_tgt[ch])
    );
  end

  assign rd_code = code_arr[CH_READ];
  assign wr_code = code_arr[CH_WRITE];
  assign settled = &at_tgt;

  // R6: settled and locked means the codes hold
  p_settled_hold_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (settled && dll_locked) |=> (rd_code == $past(rd_code) && wr_code == $past(wr_code)));

  // R9: codes are zero while the internal reset is held
  p_reset_zero_r9: assert property (@(posedge clk)
    !rst_int_n |-> (rd_code == '0 && wr_code == '0));
endmodule

// File: tb/dqs_phase_ctrl_tb.sv
module dqs_phase_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 8;
  localparam int ADJ_W  = 6;
  localparam int MAXC   = (1 << CODE_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              dll_locked;
  logic [CODE_W-1:0] dll_code;
  logic [ADJ_W-1:0]  rd_adj, wr_adj;
  logic              adj_stb;
  logic [CODE_W-1:0] rd_code, wr_code;
  logic              settled;

  dqs_phase_ctrl #(.CODE_W(CODE_W), .ADJ_W(ADJ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dll_locked(dll_locked), .dll_code(dll_code),
    .rd_adj(rd_adj), .wr_adj(wr_adj), .adj_stb(adj_stb),
    .rd_code(rd_code), .wr_code(wr_code), .settled(settled)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R9";
  bit    done = 0;

  // behavioural reference
  int m_rd, m_wr, m_adj_rd, m_adj_wr, m_rel;

  function automatic int clampc(int v);
    if (v < 0) return 0;
    if (v > MAXC) return MAXC;
    return v;
  endfunction

  function automatic int sgn(logic [ADJ_W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int stepto(int c, int t);
    if (c < t) return c + 1;
    if (c > t) return c - 1;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rd = 0; m_wr = 0; m_adj_rd = 0; m_adj_wr = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else if (!dll_locked) begin
      m_rd = int'(dll_code); m_wr = int'(dll_code);
      m_adj_rd = 0; m_adj_wr = 0;
    end else begin
      m_rd = stepto(m_rd, clampc(int'(dll_code) + m_adj_rd));
      m_wr = stepto(m_wr, clampc(int'(dll_code) + m_adj_wr));
      if (adj_stb) begin
        m_adj_rd = sgn(rd_adj);
        m_adj_wr = sgn(wr_adj);
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int exp_set;
      exp_set = (m_rd == clampc(int'(dll_code) + m_adj_rd)) &&
                (m_wr == clampc(int'(dll_code) + m_adj_wr));
      check(cur_req, "rd_code", int'(rd_code), m_rd);
      check(cur_req, "wr_code", int'(wr_code), m_wr);
      check(cur_req, "settled", int'(settled), exp_set);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(int r, int w);
    rd_adj = ADJ_W'(r); wr_adj = ADJ_W'(w); adj_stb = 1'b1;
    step(1);
    adj_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; dll_locked = 1'b0; dll_code = 8'd40;
    rd_adj = '0; wr_adj = '0; adj_stb = 1'b0;
    step(3);
    check("R9", "rd_code in reset", int'(rd_code), 0);
    rst_n = 1'b1;
    step(1);
    check("R9", "wr_code after release", int'(wr_code), 0);
    cur_req = "R4";
    step(5);
    check("R4", "rd_code unlocked", int'(rd_code), 40);

    cur_req = "R1";
    dll_locked = 1'b1;
    step(3);
    check("R1", "settled zero trim", int'(settled), 1);

    cur_req = "R5";
    strobe(5, -3);
    check("R5", "rd_code edge of strobe", int'(rd_code), 40);
    step(1);
    check("R5", "rd_code first step", int'(rd_code), 41);
    step(10);
    check("R2", "rd_code own trim", int'(rd_code), 45);
    check("R2", "wr_code own trim", int'(wr_code), 37);

    cur_req = "R10";
    rd_adj = ADJ_W'(20); wr_adj = ADJ_W'(10);
    step(5);
    check("R10", "rd_code no strobe", int'(rd_code), 45);
    check("R10", "wr_code no strobe", int'(wr_code), 37);

    cur_req = "R7";
    strobe(-10, -3);
    step(3);
    strobe(8, -3);
    step(25);
    check("R7", "rd_code replaced target", int'(rd_code), 48);

    cur_req = "R3";
    strobe(31, -32);
    step(45);
    check("R3", "rd_code positive trim", int'(rd_code), 71);
    check("R3", "wr_code negative trim", int'(wr_code), 8);

    cur_req = "R8";
    dll_code = 8'd240;
    step(250);
    check("R3", "rd_code clamped high", int'(rd_code), 255);
    check("R8", "wr_code new base", int'(wr_code), 208);

    dll_code = 8'd10;
    step(260);
    check("R3", "wr_code clamped low", int'(wr_code), 0);
    check("R8", "rd_code new base", int'(rd_code), 41);

    cur_req = "R4";
    dll_locked = 1'b0;
    step(2);
    dll_locked = 1'b1;
    step(3);
    check("R4", "rd_code after relock", int'(rd_code), 10);
    check("R4", "wr_code after relock", int'(wr_code), 10);
    cur_req = "R6";
    check("R6", "settled after relock", int'(settled), 1);
    step(4);
    check("R6", "rd_code holds", int'(rd_code), 10);
    finish_run();
  end
endmodule